// File: doc/BRIEF.md
# Flash Erase Sequencer with Suspend

This block drives the erase of a word-addressed flash array. After one start strobe it picks the span to clear: either the aligned page that holds the given word address, or a whole bank region in the chosen partition. It then writes all-ones to each word in the span, from the lowest address upward. Words are paced by a programmable wait, so the engine spends several cycles on each word, as a real array would.

Software can stop an erase that is running by setting a suspend request bit. The engine checks this bit only between words, so the word it is writing always finishes. It then ends the operation early. Words already written hold all-ones and every later word keeps its old contents. The request bit clears itself when the engine stops. A suspended erase is not resumed: software must issue a new erase. An illegal bank erase ends at once with an error and writes nothing.

Top module: `flash_erase_top`

## Requirements
- R1: A page erase (`erase_bank_i`=0) writes exactly PAGE_WORDS words, starting at the given address rounded down to a multiple of PAGE_WORDS, in the selected bank and partition.
- R2: A bank erase of the data partition (partition code 0) writes every one of the BANK_WORDS words of the bank, starting at word 0.
- R3: A bank erase of the first info partition (partition code 1) writes words 0 to INFO_WORDS-1 only.
- R4: Every word the engine writes receives the value all-ones, and no word outside the selected span changes.
- R5: A suspend request written while no erase is running is ignored. `suspend_o` reads 0 on the next cycle, and a later erase runs to completion.
- R6: A suspend request written during an erase reads back as 1 until the engine stops. It reads 0 in the cycle in which `done_o` pulses.
- R7: Words are written in ascending address order. When a suspend request is set in the cycle after the k-th write, exactly k words are erased and the rest of the span keeps its old contents.
- R8: A bank erase of any partition code other than 0 or 1 pulses `done_o` with `err_o`=1 in the cycle after start and performs no write.
- R9: A bank erase whose bit in `bank_en_i` is clear pulses `done_o` with `err_o`=1 in the cycle after start and performs no write. Page erases ignore `bank_en_i`.
- R10: `done_o` is a single-cycle pulse. At that pulse, `susp_flag_o` is 1 only for an erase that was suspended, and `err_o` is 0 for any legal erase. Both flags hold until the next start.
- R11: Two successive word writes of one erase are exactly WORD_DELAY+2 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, accepted while idle |
| erase_bank_i | input | 1 | 0 = page erase, 1 = bank erase |
| part_i | input | 2 | Partition code: 0 data, 1 first info, 2 second info |
| bank_i | input | BW | Bank to erase |
| addr_i | input | AW | Word address inside the bank (page erase) |
| bank_en_i | input | NUM_BANKS | Per-bank bank-erase permission |
| csr_we_i | input | 1 | Write strobe for the suspend request bit |
| csr_wdata_i | input | 1 | Value written to the suspend request bit |
| suspend_o | output | 1 | Suspend request readback |
| mem_we_o | output | 1 | Memory word write strobe |
| mem_bank_o | output | BW | Bank of the write |
| mem_part_o | output | 2 | Partition of the write |
| mem_addr_o | output | AW | Word address of the write |
| mem_data_o | output | WORD_W | Write data (all-ones while writing) |
| done_o | output | 1 | End-of-operation pulse |
| err_o | output | 1 | Last operation was rejected |
| susp_flag_o | output | 1 | Last operation was suspended |

## Verification
The assertions assume that `start_i` is raised only while the engine is idle. They also assume that a page erase in an info partition names a word inside that partition's INFO_WORDS. The bench keeps to both: it pulses start once and waits for `done_o` before the next vector, and every info-partition page address in its table is below INFO_WORDS. The ascending-address property also assumes a single erase at a time, so the checker resets its address history on each accepted start.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;

  typedef enum logic [1:0] {
    PART_DATA  = 2'd0,
    PART_INFO0 = 2'd1,
    PART_INFO1 = 2'd2
  } part_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_WRITE = 2'd2
  } seq_state_e;

  // Rounds a word address down to its page base.
  function automatic int unsigned page_base(input int unsigned addr,
                                            input int unsigned page_words);
    return addr - (addr % page_words);
  endfunction

  // A bank erase is accepted only for the data and the first info partition.
  function automatic logic bank_part_ok(input logic [1:0] part);
    return (part == PART_DATA) || (part == PART_INFO0);
  endfunction

  // Number of words an erase covers.
  function automatic int unsigned span_words(input logic is_bank, input logic [1:0] part,
                                             input int unsigned page_words,
                                             input int unsigned bank_words,
                                             input int unsigned info_words);
    if (!is_bank) return page_words;
    if (part == PART_DATA) return bank_words;
    return info_words;
  endfunction

endpackage

// File: rtl/flash_erase_range.sv
module flash_erase_range
  import flash_erase_pkg::*;
#(
  parameter int unsigned NUM_BANKS  = 2,
  parameter int unsigned BANK_WORDS = 64,
  parameter int unsigned PAGE_WORDS = 8,
  parameter int unsigned INFO_WORDS = 16,
  localparam int unsigned AW = $clog2(BANK_WORDS),
  localparam int unsigned BW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 is_bank,
  input  logic [1:0]           part,
  input  logic [BW-1:0]        bank,
  input  logic [AW-1:0]        addr,
  input  logic [NUM_BANKS-1:0] bank_en,
  output logic [AW-1:0]        first,
  output logic [AW-1:0]        last,
  output logic                 legal
);
  int unsigned base_w;
  int unsigned cnt_w;

  always_comb begin
    base_w = is_bank ? 0 : page_base(int'(addr), PAGE_WORDS);
    cnt_w  = span_words(is_bank, part, PAGE_WORDS, BANK_WORDS, INFO_WORDS);
    first  = AW'(base_w);
    last   = AW'(base_w + cnt_w - 1);
    legal  = !is_bank || (bank_part_ok(part) && bank_en[bank]);
  end
endmodule

// File: rtl/flash_erase_susp.sv
module flash_erase_susp (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_data,
  input  logic busy,
  input  logic finish,
  output logic req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           req <= 1'b0;
    else if (finish)                      req <= 1'b0;
    else if (wr_en && wr_data && busy)    req <= 1'b1;
  end
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import flash_erase_pkg::*;
#(
  parameter int unsigned AW         = 6,
  parameter int unsigned BW         = 1,
  parameter int unsigned WORD_DELAY = 2,
  localparam int unsigned CW = (WORD_DELAY > 0) ? $clog2(WORD_DELAY + 1) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          legal,
  input  logic [AW-1:0] first,
  input  logic [AW-1:0] last,
  input  logic [BW-1:0] bank_in,
  input  logic [1:0]    part_in,
  input  logic          susp_req,
  output logic          busy,
  output logic          finish,
  output logic          start_bad,
  output logic          we,
  output logic [AW-1:0] addr,
  output logic [BW-1:0] bank,
  output logic [1:0]    part,
  output logic          done,
  output logic          err,
  output logic          susp_flag
);
  seq_state_e    st;
  logic [AW-1:0] last_q;
  logic [CW-1:0] cnt;
  logic          at_end;
  logic          stop_now;

  assign busy      = (st != ST_IDLE);
  assign we        = (st == ST_WRITE);
  assign at_end    = (addr == last_q);
  assign stop_now  = (st == ST_WAIT) && susp_req;
  assign finish    = stop_now || (we && at_end);
  assign start_bad = (st == ST_IDLE) && start && !legal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      addr      <= '0;
      last_q    <= '0;
      cnt       <= '0;
      bank      <= '0;
      part      <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
      susp_flag <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: if (start) begin
          err       <= !legal;
          susp_flag <= 1'b0;
          if (legal) begin
            addr   <= first;
            last_q <= last;
            bank   <= bank_in;
            part   <= part_in;
            cnt    <= CW'(WORD_DELAY);
            st     <= ST_WAIT;
          end else begin
            done <= 1'b1;
          end
        end
        ST_WAIT: begin
          if (stop_now) begin
            st        <= ST_IDLE;
            done      <= 1'b1;
            susp_flag <= 1'b1;
          end else if (cnt == '0) begin
            st <= ST_WRITE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_WRITE: begin
          if (at_end) begin
            st   <= ST_IDLE;
            done <= 1'b1;
          end else begin
            addr <= addr + 1'b1;
            cnt  <= CW'(WORD_DELAY);
            st   <= ST_WAIT;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_erase_top.sv
module flash_erase_top
  import flash_erase_pkg::*;
#(
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned NUM_BANKS  = 2,
  parameter int unsigned BANK_WORDS = 64,
  parameter int unsigned PAGE_WORDS = 8,
  parameter int unsigned INFO_WORDS = 16,
  parameter int unsigned WORD_DELAY = 2,
  localparam int unsigned AW = $clog2(BANK_WORDS),
  localparam int unsigned BW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 erase_bank_i,
  input  logic [1:0]           part_i,
  input  logic [BW-1:0]        bank_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [NUM_BANKS-1:0] bank_en_i,
  input  logic                 csr_we_i,
  input  logic                 csr_wdata_i,
  output logic                 suspend_o,
  output logic                 mem_we_o,
  output logic [BW-1:0]        mem_bank_o,
  output logic [1:0]           mem_part_o,
  output logic [AW-1:0]        mem_addr_o,
  output logic [WORD_W-1:0]    mem_data_o,
  output logic                 done_o,
  output logic                 err_o,
  output logic                 susp_flag_o
);
  logic [AW-1:0] span_first;
  logic [AW-1:0] span_last;
  logic          span_legal;
  logic          busy;
  logic          finish;
  logic          start_bad;

  flash_erase_range #(
    .NUM_BANKS(NUM_BANKS), .BANK_WORDS(BANK_WORDS),
    .PAGE_WORDS(PAGE_WORDS), .INFO_WORDS(INFO_WORDS)
  ) u_range (
    .is_bank(erase_bank_i), .part(part_i), .bank(bank_i), .addr(addr_i),
    .bank_en(bank_en_i), .first(span_first), .last(span_last), .legal(span_legal)
  );

  flash_erase_seq #(.AW(AW), .BW(BW), .WORD_DELAY(WORD_DELAY)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start_i), .legal(span_legal),
    .first(span_first), .last(span_last), .bank_in(bank_i), .part_in(part_i),
    .susp_req(suspend_o), .busy(busy), .finish(finish), .start_bad(start_bad),
    .we(mem_we_o), .addr(mem_addr_o), .bank(mem_bank_o), .part(mem_part_o),
    .done(done_o), .err(err_o), .susp_flag(susp_flag_o)
  );

  flash_erase_susp u_susp (
    .clk(clk), .rst_n(rst_n), .wr_en(csr_we_i), .wr_data(csr_wdata_i),
    .busy(busy), .finish(finish), .req(suspend_o)
  );

  assign mem_data_o = {WORD_W{mem_we_o}};
endmodule

// File: rtl/flash_erase_chk.sv
module flash_erase_chk #(
  parameter int unsigned AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          busy,
  input logic          start_bad,
  input logic          suspend_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          done_o,
  input logic          err_o
);
  logic          prev_v;
  logic [AW-1:0] prev_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_v <= 1'b0;
      prev_a <= '0;
    end else if (start_i && !busy) begin
      prev_v <= 1'b0;
    end else if (mem_we_o) begin
      prev_v <= 1'b1;
      prev_a <= mem_addr_o;
    end
  end

  AST_SUSP_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !suspend_o);  // R5
  AST_SUSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_o |=> (suspend_o || done_o));  // R6
  AST_ADDR_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && prev_v) |-> (mem_addr_o == prev_a + 1'b1));  // R7
  AST_REJECT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    start_bad |=> (done_o && err_o && !mem_we_o));  // R8, R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);  // R10
endmodule

bind flash_erase_top flash_erase_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy(busy), .start_bad(start_bad),
  .suspend_o(suspend_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
  .done_o(done_o), .err_o(err_o)
);

// File: tb/sim_flash_erase_top.sv
module sim_flash_erase_top;
  localparam int NB = 2, BWORDS = 64, PWORDS = 8, IWORDS = 16, DLY = 2;
  localparam logic [31:0] ONES = 32'hFFFF_FFFF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 0, erase_bank_i = 0, csr_we_i = 0, csr_wdata_i = 0;
  logic [1:0] part_i = 0;
  logic [0:0] bank_i = 0;
  logic [5:0] addr_i = 0;
  logic [1:0] bank_en_i = 0;
  logic suspend_o, mem_we_o, done_o, err_o, susp_flag_o;
  logic [0:0] mem_bank_o;
  logic [1:0] mem_part_o;
  logic [5:0] mem_addr_o;
  logic [31:0] mem_data_o;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [31:0] mem [NB][4][BWORDS];
  logic [31:0] expm [NB][4][BWORDS];

  always #10 clk = ~clk;

  flash_erase_top #(.NUM_BANKS(NB), .BANK_WORDS(BWORDS), .PAGE_WORDS(PWORDS),
                    .INFO_WORDS(IWORDS), .WORD_DELAY(DLY)) u0 (.*);

  // Vector: [19] bank erase, [18:17] partition, [16] bank, [15:10] address,
  //         [9:8] bank enables, [7:0] suspend after this many writes (0 = none)
  localparam int NV = 9;
  localparam logic [19:0] VEC [NV] = '{
    {1'b0, 2'd0, 1'b0, 6'd13, 2'b11, 8'd0},   // R1 page, data
    {1'b0, 2'd2, 1'b1, 6'd5,  2'b00, 8'd0},   // R1 page, second info
    {1'b1, 2'd0, 1'b0, 6'd40, 2'b11, 8'd0},   // R2 bank, data
    {1'b1, 2'd1, 1'b1, 6'd9,  2'b11, 8'd0},   // R3 bank, first info
    {1'b1, 2'd2, 1'b0, 6'd0,  2'b11, 8'd0},   // R8 bad partition
    {1'b1, 2'd0, 1'b1, 6'd0,  2'b01, 8'd0},   // R9 bank disabled
    {1'b0, 2'd0, 1'b1, 6'd60, 2'b11, 8'd3},   // R7 page suspended
    {1'b1, 2'd0, 1'b0, 6'd0,  2'b11, 8'd10},  // R7 bank suspended
    {1'b0, 2'd1, 1'b0, 6'd15, 2'b00, 8'd1}    // R7 info page suspended
  };

  function automatic logic [31:0] pat(int b, int p, int a);
    return 32'h5A00_0000 | (b << 12) | (p << 8) | a;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_vec(input logic [19:0] v);
    int isb = v[19], p = v[18:17], b = v[16], a = v[15:10], k = v[7:0];
    bit legal = !isb || ((p == 0 || p == 1) && v[8 + b]);
    int base = isb ? 0 : a - (a % PWORDS);
    int cnt = !isb ? PWORDS : (p == 0 ? BWORDS : IWORDS);
    int n = !legal ? 0 : (k != 0 ? k : cnt);
    int wr = 0, last_cyc = 0, cyc = 0, bad_gap = 0, mism = 0;
    bit pend = 0, seen = 0;
    for (int bb = 0; bb < NB; bb++)
      for (int pp = 0; pp < 4; pp++)
        for (int aa = 0; aa < BWORDS; aa++) begin
          mem[bb][pp][aa] = pat(bb, pp, aa);
          expm[bb][pp][aa] = pat(bb, pp, aa);
        end
    for (int j = 0; j < n; j++) expm[b][p][base + j] = ONES;
    erase_bank_i = v[19]; part_i = v[18:17]; bank_i = v[16]; addr_i = v[15:10];
    bank_en_i = v[9:8]; start_i = 1;
    @(negedge clk);
    start_i = 0;
    while (cyc < 2000) begin
      if (pend) begin
        csr_we_i = 0; csr_wdata_i = 0; pend = 0;
        check(suspend_o == 1 && !done_o, "R6 held", suspend_o, 1);
      end
      if (mem_we_o) begin
        mem[mem_bank_o][mem_part_o][mem_addr_o] = mem_data_o;
        if (wr > 0 && cyc - last_cyc != DLY + 2) bad_gap++;
        last_cyc = cyc;
        wr++;
        if (k != 0 && wr == k) begin
          csr_we_i = 1; csr_wdata_i = 1; pend = 1;
        end
      end
      if (done_o) begin seen = 1; break; end
      @(negedge clk);
      cyc++;
    end
    check(seen, "R10 done seen", seen, 1);
    check(err_o == !legal, legal ? "R10 err clear" : (p > 1 ? "R8 err" : "R9 err"),
          err_o, !legal);
    check(susp_flag_o == (legal && k != 0), "R10 suspended flag", susp_flag_o,
          legal && k != 0);
    check(suspend_o == 0, "R6 cleared at done", suspend_o, 0);
    check(wr == n, "R7 word count", wr, n);
    check(bad_gap == 0, "R11 pacing", bad_gap, 0);
    for (int bb = 0; bb < NB; bb++)
      for (int pp = 0; pp < 4; pp++)
        for (int aa = 0; aa < BWORDS; aa++)
          if (mem[bb][pp][aa] !== expm[bb][pp][aa]) mism++;
    check(mism == 0, "R4 memory contents (R1 R2 R3 R7)", mism, 0);
    @(negedge clk);
    check(done_o == 0, "R10 single pulse", done_o, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!done_o && !err_o && !suspend_o && !mem_we_o && !susp_flag_o,
          "R10 reset state", {done_o, err_o, suspend_o, mem_we_o}, 0);
    for (int i = 0; i < NV; i++) run_vec(VEC[i]);
    // R5: suspend request while idle is dropped
    csr_we_i = 1; csr_wdata_i = 1;
    @(negedge clk);
    csr_we_i = 0; csr_wdata_i = 0;
    check(suspend_o == 0, "R5 idle request ignored", suspend_o, 0);
    @(negedge clk);
    check(suspend_o == 0, "R5 still zero", suspend_o, 0);
    run_vec({1'b0, 2'd0, 1'b0, 6'd33, 2'b00, 8'd0});  // R5 full erase afterwards
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule